// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block decides which interrupt a small 16-bit processor takes next and then carries out the entry itself. Requests come in as level flags, one per source. Index 0 is the reset source. Index 1 is the non-maskable source. All higher indices are maskable and need the global enable bit of the status word. The lowest pending index wins. Each index owns one vector word, and index `i` reads its vector at `0xFFFE - 2*i`.

Entry starts only at an instruction boundary, which the processor signals with `insn_done`. The block captures the current program counter, status word and stack pointer. It pushes the return address and then the status word over a write port, reads the vector over a read port, and hands the processor a new program counter and stack pointer together with a status-clear pulse. Both memory ports use valid/ready. A write holds its address and data, and the sequence waits, for as long as `wr_ready` is low. A read completes in the cycle in which `rd_valid` and `rd_ready` are both high, and `rd_data` is taken in that same cycle.

A reset entry skips both pushes and sets the stack pointer to zero. A reset entry also runs once, on its own, after the block reset is released. If the reset vector reads `0xFFFF`, the block halts. It then stays halted and ignores all requests until the block reset is applied again. Every entry pulses a one-hot acknowledge. Flags that own a vector alone also get a clear pulse. Flags that share a vector get no clear pulse and are left pending for software.

Top module: `irq_entry_seq`

## Requirements
- R1: An entry begins only on a clock edge at which the sequencer is idle and `insn_done` is high. While `insn_done` is low, pending requests leave `busy` low.
- R2: The lowest pending eligible index wins. The vector read for index `i` uses address `0xFFFE - 2*i`.
- R3: Index 1 is taken whatever the value of the global enable. Indices 2 and above are taken only when status bit 3 (the global enable) of `cur_sr` is 1.
- R4: A non-reset entry first writes the return address to `SP-2` and then the status word to `SP-4`. Each write holds `wr_valid`, `wr_addr` and `wr_data` steady until `wr_ready` is high.
- R5: `irq_ack` pulses one-hot at the winning index in the load cycle. `flag_clr` pulses the same bit only when that index's `SHARED_MASK` bit is 0, and is all zero otherwise.
- R6: In the load cycle, `pc_load` and `sr_clear` are high, `new_pc` is the vector word, and `new_sp` is the captured stack pointer minus 4.
- R7: With no stalls, `pc_load` is high in the fifth cycle after the edge at which the request was accepted (six cycles in all, counting the cycle in which the request was seen).
- R8: A reset entry (index 0, or the automatic one after block reset) does no writes, gives `new_sp = 0`, and loads the vector three edges after the request is seen.
- R9: If a reset entry reads `0xFFFF`, there is no `pc_load` and `halted` goes high the following cycle. After that, `halted` stays high, `busy` and `wr_valid` stay low, and all requests are ignored.
- R10: While the block reset is held, `busy`, `pc_load`, `wr_valid`, `rd_valid` and `halted` are low.
- R11: `busy` is high from the first decision cycle through the load cycle and low in the cycle that follows. No new arbitration happens while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| req | input | NSRC | Level request flags, index 0 highest priority |
| insn_done | input | 1 | Processor is at an instruction boundary |
| cur_pc | input | DW | Address of the next instruction |
| cur_sr | input | DW | Current status word; bit 3 is the global enable |
| cur_sp | input | AW | Current stack pointer |
| wr_valid | output | 1 | Stack write request |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | AW | Stack write address |
| wr_data | output | DW | Stack write data |
| rd_valid | output | 1 | Vector read request |
| rd_ready | input | 1 | Memory returns `rd_data` this cycle |
| rd_addr | output | AW | Vector address |
| rd_data | input | DW | Vector word |
| busy | output | 1 | Entry sequence in progress |
| pc_load | output | 1 | Load `new_pc` and `new_sp` this cycle |
| new_pc | output | DW | Vector word for the program counter |
| new_sp | output | AW | Stack pointer after entry |
| sr_clear | output | 1 | Clear the whole status word this cycle |
| irq_ack | output | NSRC | One-hot acknowledge of the taken source |
| flag_clr | output | NSRC | Automatic clear for sources that own a vector alone |
| halted | output | 1 | Disabled after an erased reset vector |

## Verification
The bench drives each request one cycle after a clock edge. It expects `busy` after the next edge and, with no stalls, the load cycle five edges later for ordinary entries and three edges later for reset entries. Each scenario checks its result by stepping exactly that many edges and sampling one time unit after the edge. Write back-pressure adds one cycle for each cycle `wr_ready` is low, and the stall scenario counts those cycles before it checks. In parallel, a behavioural reference model advances on every edge and is compared with the outputs at every falling edge. Because of this, the timing of every push, read and acknowledge is checked in every scenario.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DECIDE = 3'd1,
    ST_PUSHRA = 3'd2,
    ST_PUSHSR = 3'd3,
    ST_FETCH  = 3'd4,
    ST_LOAD   = 3'd5,
    ST_HALT   = 3'd6
  } seq_state_t;

  function automatic logic [15:0] vector_of(input logic [15:0] top, input int unsigned idx);
    logic [15:0] off;
    off = 16'(idx << 1);
    return top - off;
  endfunction

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NSRC = 16,
  parameter int IDXW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] req,
  input  logic            boot,
  input  logic            gie,
  output logic            found,
  output logic [IDXW-1:0] win
);
  logic [NSRC-1:0] elig;

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_elig
    if (gi == 0) begin : g_rst
      assign elig[gi] = req[gi] | boot;
    end else if (gi == 1) begin : g_nmi
      assign elig[gi] = req[gi];
    end else begin : g_mask
      assign elig[gi] = req[gi] & gie;
    end
  end

  assign found = |elig;

  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) win = IDXW'(i);
    end
  end
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_entry_pkg::*;
#(
  parameter int          NSRC    = 16,
  parameter int          AW      = 16,
  parameter int          DW      = 16,
  parameter logic [15:0] VEC_TOP = 16'hFFFE,
  parameter int          IDXW    = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_done,
  input  logic            found,
  input  logic [IDXW-1:0] win,
  input  logic [DW-1:0]   cur_pc,
  input  logic [DW-1:0]   cur_sr,
  input  logic [AW-1:0]   cur_sp,
  output logic            boot_pend,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [AW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [AW-1:0]   rd_addr,
  input  logic [DW-1:0]   rd_data,
  output logic            busy,
  output logic            pc_load,
  output logic [DW-1:0]   new_pc,
  output logic [AW-1:0]   new_sp,
  output logic            sr_clear,
  output logic            load_cycle,
  output logic [IDXW-1:0] taken,
  output logic            halted
);
  localparam logic [AW-1:0] WSTEP = AW'(2);
  localparam logic [DW-1:0] ERASED = '1;

  seq_state_t      state_q;
  logic [IDXW-1:0] win_q;
  logic [DW-1:0]   pc_q, sr_q, vec_q;
  logic [AW-1:0]   sp_q;
  logic            boot_q;
  logic            is_rst, vec_erased;

  assign is_rst     = (win_q == '0);
  assign vec_erased = (vec_q == ERASED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      win_q   <= '0;
      pc_q    <= '0;
      sr_q    <= '0;
      sp_q    <= '0;
      vec_q   <= '0;
      boot_q  <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: if (insn_done && found) begin
          win_q   <= win;
          pc_q    <= cur_pc;
          sr_q    <= cur_sr;
          sp_q    <= cur_sp;
          state_q <= ST_DECIDE;
        end
        ST_DECIDE: begin
          if (is_rst) begin
            sp_q    <= '0;
            state_q <= ST_FETCH;
          end else begin
            state_q <= ST_PUSHRA;
          end
        end
        ST_PUSHRA: if (wr_ready) begin
          sp_q    <= sp_q - WSTEP;
          state_q <= ST_PUSHSR;
        end
        ST_PUSHSR: if (wr_ready) begin
          sp_q    <= sp_q - WSTEP;
          state_q <= ST_FETCH;
        end
        ST_FETCH: if (rd_ready) begin
          vec_q   <= rd_data;
          state_q <= ST_LOAD;
        end
        ST_LOAD: begin
          if (is_rst) boot_q <= 1'b0;
          state_q <= (is_rst && vec_erased) ? ST_HALT : ST_IDLE;
        end
        ST_HALT: state_q <= ST_HALT;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign boot_pend  = boot_q;
  assign wr_valid   = (state_q == ST_PUSHRA) || (state_q == ST_PUSHSR);
  assign wr_addr    = sp_q - WSTEP;
  assign wr_data    = (state_q == ST_PUSHRA) ? pc_q : sr_q;
  assign rd_valid   = (state_q == ST_FETCH);
  assign rd_addr    = AW'(vector_of(VEC_TOP, int'(win_q)));
  assign busy       = (state_q != ST_IDLE) && (state_q != ST_HALT);
  assign load_cycle = (state_q == ST_LOAD);
  assign pc_load    = load_cycle && !(is_rst && vec_erased);
  assign sr_clear   = pc_load;
  assign new_pc     = vec_q;
  assign new_sp     = sp_q;
  assign taken      = win_q;
  assign halted     = (state_q == ST_HALT);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int              NSRC        = 16,
  parameter int              AW          = 16,
  parameter int              DW          = 16,
  parameter int              GIE_BIT     = 3,
  parameter logic [15:0]     VEC_TOP     = 16'hFFFE,
  parameter logic [NSRC-1:0] SHARED_MASK = NSRC'(16'h0030)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic            insn_done,
  input  logic [DW-1:0]   cur_pc,
  input  logic [DW-1:0]   cur_sr,
  input  logic [AW-1:0]   cur_sp,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [AW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [AW-1:0]   rd_addr,
  input  logic [DW-1:0]   rd_data,
  output logic            busy,
  output logic            pc_load,
  output logic [DW-1:0]   new_pc,
  output logic [AW-1:0]   new_sp,
  output logic            sr_clear,
  output logic [NSRC-1:0] irq_ack,
  output logic [NSRC-1:0] flag_clr,
  output logic            halted
);
  localparam int IDXW = $clog2(NSRC);

  logic            found, boot_pend, load_cycle;
  logic [IDXW-1:0] win, taken;

  irq_prio_pick #(.NSRC(NSRC), .IDXW(IDXW)) u_pick (
    .req   (req),
    .boot  (boot_pend),
    .gie   (cur_sr[GIE_BIT]),
    .found (found),
    .win   (win)
  );

  irq_entry_fsm #(
    .NSRC(NSRC), .AW(AW), .DW(DW), .VEC_TOP(VEC_TOP), .IDXW(IDXW)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_done  (insn_done),
    .found      (found),
    .win        (win),
    .cur_pc     (cur_pc),
    .cur_sr     (cur_sr),
    .cur_sp     (cur_sp),
    .boot_pend  (boot_pend),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .busy       (busy),
    .pc_load    (pc_load),
    .new_pc     (new_pc),
    .new_sp     (new_sp),
    .sr_clear   (sr_clear),
    .load_cycle (load_cycle),
    .taken      (taken),
    .halted     (halted)
  );

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_ack
    assign irq_ack[gi]  = load_cycle && (taken == IDXW'(gi));
    assign flag_clr[gi] = irq_ack[gi] && !SHARED_MASK[gi];
  end
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int              NSRC        = 16,
  parameter int              AW          = 16,
  parameter int              DW          = 16,
  parameter logic [NSRC-1:0] SHARED_MASK = NSRC'(16'h0030)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic [AW-1:0]   wr_addr,
  input logic [DW-1:0]   wr_data,
  input logic            rd_valid,
  input logic            busy,
  input logic            pc_load,
  input logic            sr_clear,
  input logic [NSRC-1:0] irq_ack,
  input logic [NSRC-1:0] flag_clr,
  input logic            halted
);
  // R4
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  // R4
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rd_valid));
  // R5
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_ack));
  // R5
  clr_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_clr & ~irq_ack) == '0) && ((flag_clr & SHARED_MASK) == '0));
  // R6
  load_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> sr_clear && $onehot(irq_ack));
  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && !pc_load && !busy);
  // R11
  load_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !busy);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .NSRC(NSRC), .AW(AW), .DW(DW), .SHARED_MASK(SHARED_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .rd_valid(rd_valid), .busy(busy),
  .pc_load(pc_load), .sr_clear(sr_clear), .irq_ack(irq_ack),
  .flag_clr(flag_clr), .halted(halted)
);

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;
  localparam int          NSRC   = 16;
  localparam logic [15:0] SHARED = 16'h0030;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req = '0;
  logic        insn_done = 1'b0;
  logic [15:0] cur_pc = 16'h1234, cur_sr = 16'h0000, cur_sp = 16'h0400;
  logic        wr_ready = 1'b1, rd_ready = 1'b1;
  logic        wr_valid, rd_valid, busy, pc_load, sr_clear, halted;
  logic [15:0] wr_addr, wr_data, rd_addr, rd_data, new_pc, new_sp;
  logic [15:0] irq_ack, flag_clr;
  logic [15:0] rst_word = 16'hC000;

  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  function automatic logic [15:0] vword(input logic [15:0] a);
    return (a == 16'hFFFE) ? rst_word : (16'h8000 | {8'h00, a[7:0]});
  endfunction

  assign rd_data = vword(rd_addr);

  irq_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .req(req), .insn_done(insn_done),
    .cur_pc(cur_pc), .cur_sr(cur_sr), .cur_sp(cur_sp),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .pc_load(pc_load), .new_pc(new_pc), .new_sp(new_sp),
    .sr_clear(sr_clear), .irq_ack(irq_ack), .flag_clr(flag_clr), .halted(halted)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 decide, 2/3 pushes, 4 read, 5 load, 6 halted
  int          m_ph = 0, m_win = 0;
  logic [15:0] m_sp = '0, m_pc = '0, m_sr = '0, m_vec = '0;
  bit          m_boot = 1'b1;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_boot = 1'b1; m_win = 0;
    end else begin
      case (m_ph)
        0: if (insn_done) begin
          int w;
          w = -1;
          for (int i = NSRC - 1; i >= 0; i--)
            if ((i == 0 && (req[0] || m_boot)) || (i == 1 && req[1]) ||
                (i >= 2 && req[i] && cur_sr[3])) w = i;
          if (w >= 0) begin
            m_win = w; m_pc = cur_pc; m_sr = cur_sr; m_sp = cur_sp; m_ph = 1;
          end
        end
        1: begin
          if (m_win == 0) begin m_sp = 16'h0000; m_ph = 4; end
          else m_ph = 2;
        end
        2, 3: if (wr_ready) begin m_sp = m_sp - 16'd2; m_ph = m_ph + 1; end
        4: if (rd_ready) begin m_vec = vword(16'hFFFE - 16'(2 * m_win)); m_ph = 5; end
        5: begin
          if (m_win == 0) m_boot = 1'b0;
          m_ph = (m_win == 0 && m_vec == 16'hFFFF) ? 6 : 0;
        end
        default: m_ph = 6;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic ld;
      logic [15:0] ack;
      ld  = (m_ph == 5) && !(m_win == 0 && m_vec == 16'hFFFF);
      ack = (m_ph == 5) ? (16'h0001 << m_win) : 16'h0000;
      chk("R11 busy", 32'(busy), 32'(m_ph >= 1 && m_ph <= 5));
      chk("R4 wr_valid", 32'(wr_valid), 32'(m_ph == 2 || m_ph == 3));
      if (m_ph == 2 || m_ph == 3) begin
        chk("R4 wr_addr", 32'(wr_addr), 32'(m_sp - 16'd2));
        chk("R4 wr_data", 32'(wr_data), 32'((m_ph == 2) ? m_pc : m_sr));
      end
      chk("R2 rd_valid", 32'(rd_valid), 32'(m_ph == 4));
      if (m_ph == 4) chk("R2 rd_addr", 32'(rd_addr), 32'(16'hFFFE - 16'(2 * m_win)));
      chk("R6 pc_load", 32'(pc_load), 32'(ld));
      chk("R6 sr_clear", 32'(sr_clear), 32'(ld));
      if (ld) begin
        chk("R6 new_pc", 32'(new_pc), 32'(m_vec));
        chk("R6 new_sp", 32'(new_sp), 32'(m_sp));
      end
      chk("R5 irq_ack", 32'(irq_ack), 32'(ack));
      chk("R5 flag_clr", 32'(flag_clr), 32'(ack & ~SHARED));
      chk("R9 halted", 32'(halted), 32'(m_ph == 6));
    end
  end

  always @(posedge clk) begin
    if (cyc > 5000) begin
      fails++; checks++;
      $display("FAIL R11 watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    step(3);
    // R10 reset state
    chk("R10 busy", 32'(busy), 0);
    chk("R10 pc_load", 32'(pc_load), 0);
    chk("R10 wr_valid", 32'(wr_valid), 0);
    chk("R10 rd_valid", 32'(rd_valid), 0);
    chk("R10 halted", 32'(halted), 0);
    rst_n = 1'b1;
    step(3);
    chk("R1 no entry without boundary", 32'(busy), 0);
    // R8 automatic reset entry
    insn_done = 1'b1;
    step(3);
    chk("R8 load", 32'(pc_load), 1);
    chk("R8 new_pc", 32'(new_pc), 32'h0000C000);
    chk("R8 new_sp", 32'(new_sp), 0);
    chk("R8 ack", 32'(irq_ack), 1);
    step(1);
    chk("R11 idle after load", 32'(busy), 0);
    // R3 masked request ignored
    req = 16'h0020;
    step(6);
    chk("R3 masked busy", 32'(busy), 0);
    chk("R3 masked load", 32'(pc_load), 0);
    // R2 R7 priority and timing
    cur_sr = 16'h0008;
    req = 16'h0028;
    step(5);
    chk("R7 load at fifth edge", 32'(pc_load), 1);
    chk("R2 ack winner", 32'(irq_ack), 32'h0008);
    chk("R2 vector", 32'(new_pc), 32'h000080F8);
    chk("R6 sp minus four", 32'(new_sp), 32'h000003FC);
    chk("R5 single clr", 32'(flag_clr), 32'h0008);
    req = 16'h0020;
    step(6);
    chk("R5 shared ack", 32'(irq_ack), 32'h0020);
    chk("R5 shared no clr", 32'(flag_clr), 0);
    req = 16'h0000;
    step(1);
    // R3 non-maskable with enable off
    cur_sr = 16'h0000;
    req = 16'h0042;
    step(5);
    chk("R3 nmi ack", 32'(irq_ack), 32'h0002);
    req = 16'h0000;
    step(1);
    // R1 boundary wait
    insn_done = 1'b0;
    req = 16'h0002;
    step(4);
    chk("R1 waits for boundary", 32'(busy), 0);
    insn_done = 1'b1;
    step(5);
    chk("R1 entry after boundary", 32'(pc_load), 1);
    req = 16'h0000;
    step(1);
    // R4 back-pressure
    wr_ready = 1'b0;
    cur_sr = 16'h0008;
    req = 16'h0004;
    step(2);
    chk("R4 ra valid", 32'(wr_valid), 1);
    chk("R4 ra addr", 32'(wr_addr), 32'h000003FE);
    chk("R4 ra data", 32'(wr_data), 32'h00001234);
    step(2);
    chk("R4 ra held addr", 32'(wr_addr), 32'h000003FE);
    chk("R4 ra held data", 32'(wr_data), 32'h00001234);
    wr_ready = 1'b1;
    step(1);
    chk("R4 sr addr", 32'(wr_addr), 32'h000003FC);
    chk("R4 sr data", 32'(wr_data), 32'h00000008);
    step(1);
    chk("R2 read addr", 32'(rd_addr), 32'h0000FFFA);
    step(1);
    chk("R6 load after stall", 32'(pc_load), 1);
    req = 16'h0000;
    step(1);
    // R9 erased reset vector
    rst_word = 16'hFFFF;
    req = 16'h0001;
    step(3);
    chk("R9 no load", 32'(pc_load), 0);
    chk("R9 ack", 32'(irq_ack), 1);
    step(1);
    chk("R9 halted", 32'(halted), 1);
    req = 16'hFFFF;
    step(8);
    chk("R9 still halted", 32'(halted), 1);
    chk("R9 not busy", 32'(busy), 0);
    chk("R9 no writes", 32'(wr_valid), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule